// File: doc/BRIEF.md
# LCD Controller Serial Command and Display Memory Slave

This block is the serial front end of a segment LCD controller. It sits on a two-wire I2C bus as a slave at the 7-bit address 0111101. A host uses it to load the controller's configuration and to fill or read back the display memory. SCL and SDA are oversampled on the system clock. SDA is driven only as an open-drain pull-down enable.

A write transfer carries an opcode byte and then a settings byte. The display-data opcode takes a start address as its settings byte, then streams data bytes into the display memory. An auto-incrementing pointer moves to the next location after each byte's acknowledge clock. The pointer wraps to zero at a limit set by the current duty. To read, the host first loads the pointer with a write transfer, then issues a repeated START with the read bit set and clocks bytes out MSB first. A separate combinational scan port lets the LCD timing logic fetch any memory byte.

Top module: `lcd_i2c_cmd_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0111101. On a mismatch it gives no acknowledge, never pulls SDA low, and ignores the rest of the transfer, so no setting changes.
- R2: After reset the pointer is 0x00, duty and bias codes are 00, oscillator and display are off, frame select is 0, blink is 00 and the voltage-adjust register is 0x30.
- R3: Opcode 0x80 followed by an address byte (bits 6:0) loads the pointer. Each following data byte is written at the pointer, and the pointer then advances by one after that byte's acknowledge clock.
- R4: On advancing, the pointer returns to 0x00 when it is at or beyond 0x23 for duty code 00, 0x43 for duty code 01, or 0x77 for duty code 10.
- R5: Opcode 0x82 takes duty from settings bits {3,1} and bias from bits {2,0}. A settings byte whose duty or bias code is 11 leaves both codes unchanged.
- R6: Opcode 0x84 stores bit1 as the oscillator enable and bit0 as the display enable. The display-enable output is high only when both bits are 1. Opcode 0x86 stores the frame-rate select from bit0, and opcode 0x88 stores the blink code from bits 1:0.
- R7: Opcode 0x8A stores settings bits 5:0 into the voltage-adjust register: bit5 is the shared-pin select, bit4 the adjust enable and bits 3:0 the level. Bits 7:6 are ignored.
- R8: An opcode outside {0x80,0x82,0x84,0x86,0x88,0x8A} changes no state. Bytes that follow a completed non-display command pair in the same transfer are acknowledged but have no effect.
- R9: After a repeated START with the read bit set, bytes stream from the pointer MSB first. The pointer advances after each acknowledge clock with the R4 wrap. A master ACK continues the stream, and after a NACK the slave releases SDA.
- R10: A START or STOP that arrives before a byte's eighth bit discards that byte: memory and settings are untouched.
- R11: SDA is pulled low only in the acknowledge slot of an addressed transfer or for a 0 data bit of a read. It is released after STOP.
- R12: Data written while the pointer is at 0x78 or above is discarded. Reads at such addresses, through the bus or the scan port, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND bus value) |
| sda_oe_o | output | 1 | High to pull SDA low |
| scan_addr_i | input | 7 | Display memory address for the LCD scanner |
| scan_data_o | output | 8 | Display memory byte at scan_addr_i |
| duty_o | output | 2 | Duty code: 00 1/4, 01 1/8, 10 1/16 |
| bias_o | output | 2 | Bias code: 00 1/3, 01 1/4, 10 1/5 |
| osc_en_o | output | 1 | Internal oscillator enable |
| disp_en_o | output | 1 | Display enable |
| frame_fast_o | output | 1 | Frame-rate select (1 = higher rate) |
| blink_o | output | 2 | Blink-rate code, 00 = off |
| vadj_o | output | 6 | Shared-pin select, adjust enable, 4-bit level |

## Verification
The whole display memory is filled in one streamed write. It is compared through the scan port and read back in one stream that runs past the top, so that every address and the 1/16 wrap are covered. For each of the three duty codes, a short write and read straddle that duty's limit, which tells the three wrap points apart. All sixteen drive-mode settings bytes are swept, so reserved codes are told apart from valid ones. System, frame, blink and voltage-adjust values are also swept. Undefined opcodes, trailing bytes after a command pair, a foreign address, transfers cut short by START or STOP mid-byte, and writes above the memory top each check that nothing changed.

// File: rtl/lcd_i2c_cmd_slave.sv
module lcd_i2c_cmd_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'b0111101,
  parameter int         RAM_BYTES = 120,
  parameter int         LIM_D4    = 35,
  parameter int         LIM_D8    = 67
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [6:0] scan_addr_i,
  output logic [7:0] scan_data_o,
  output logic [1:0] duty_o,
  output logic [1:0] bias_o,
  output logic       osc_en_o,
  output logic       disp_en_o,
  output logic       frame_fast_o,
  output logic [1:0] blink_o,
  output logic [5:0] vadj_o
);
  localparam int AW = 7;
  localparam logic [AW-1:0] RAM_END  = AW'(RAM_BYTES);
  localparam logic [AW-1:0] LIM_D16  = AW'(RAM_BYTES - 1);
  localparam logic [7:0] OP_DATA  = 8'h80;
  localparam logic [7:0] OP_DRIVE = 8'h82;
  localparam logic [7:0] OP_SYS   = 8'h84;
  localparam logic [7:0] OP_FRAME = 8'h86;
  localparam logic [7:0] OP_BLINK = 8'h88;
  localparam logic [7:0] OP_VADJ  = 8'h8A;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK} st_t;
  typedef enum logic [1:0] {PH_OPC, PH_ARG, PH_DATA, PH_SKIP} ph_t;

  st_t           state;
  ph_t           phase;
  logic [3:0]    cnt;
  logic [7:0]    sh, opc;
  logic          rw, mack, inc_pend;
  logic [AW-1:0] ptr, lim, nxt_ptr;
  logic [1:0]    duty, bias, sys, blink;
  logic          frame;
  logic [5:0]    vadj;
  logic [7:0]    ram [RAM_BYTES];

  // bus sampling and condition detection
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_done = scl_fall & (cnt == 4'd8);
  wire wr_done   = (state == ST_WR) & byte_done;
  wire ram_we    = wr_done & (phase == PH_DATA) & (ptr < RAM_END);

  always_comb
    case (duty)
      2'd0:    lim = AW'(LIM_D4);
      2'd1:    lim = AW'(LIM_D8);
      default: lim = LIM_D16;
    endcase
  assign nxt_ptr = (ptr >= lim) ? '0 : ptr + AW'(1);

  wire [7:0] rd_cur = (ptr < RAM_END) ? ram[ptr] : 8'h00;
  wire [7:0] rd_nxt = (nxt_ptr < RAM_END) ? ram[nxt_ptr] : 8'h00;
  assign scan_data_o = (scan_addr_i < RAM_END) ? ram[scan_addr_i] : 8'h00;

  always_ff @(posedge clk)
    if (ram_we) ram[ptr] <= sh;

  wire [1:0] new_duty = {sh[3], sh[1]};
  wire [1:0] new_bias = {sh[2], sh[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; phase <= PH_OPC; cnt <= '0; sh <= '0; opc <= '0;
      rw <= 1'b0; mack <= 1'b0; inc_pend <= 1'b0; ptr <= '0;
      duty <= '0; bias <= '0; sys <= '0; frame <= 1'b0; blink <= '0; vadj <= 6'h30;
    end else if (start_det) begin
      state <= ST_ADDR; cnt <= '0; phase <= PH_OPC; inc_pend <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; inc_pend <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw <= sh[0]; state <= ST_AACK;
              end else state <= ST_IDLE;
            end else begin
              state <= ST_WACK;
              case (phase)
                PH_OPC: begin opc <= sh; phase <= PH_ARG; end
                PH_ARG: begin
                  phase <= (opc == OP_DATA) ? PH_DATA : PH_SKIP;
                  case (opc)
                    OP_DATA:  ptr <= sh[AW-1:0];
                    OP_DRIVE: if (new_duty != 2'b11 && new_bias != 2'b11) begin
                                duty <= new_duty; bias <= new_bias;
                              end
                    OP_SYS:   sys   <= sh[1:0];
                    OP_FRAME: frame <= sh[0];
                    OP_BLINK: blink <= sh[1:0];
                    OP_VADJ:  vadj  <= sh[5:0];
                    default: ;
                  endcase
                end
                PH_DATA: inc_pend <= 1'b1;
                default: ;
              endcase
            end
          end
        end
        ST_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin state <= ST_RD; sh <= rd_cur; end
            else state <= ST_WR;
          end
        ST_WACK:
          if (scl_fall) begin
            state <= ST_WR; cnt <= '0;
            if (inc_pend) begin ptr <= nxt_ptr; inc_pend <= 1'b0; end
          end
        ST_RD:
          if (scl_fall) begin
            if (cnt == 4'd7) begin state <= ST_RACK; cnt <= '0; end
            else begin sh <= {sh[6:0], 1'b0}; cnt <= cnt + 4'd1; end
          end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            ptr <= nxt_ptr;
            if (mack) begin state <= ST_RD; sh <= rd_nxt; end
            else state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end

  assign sda_oe_o     = (state == ST_AACK) | (state == ST_WACK) | ((state == ST_RD) & ~sh[7]);
  assign duty_o       = duty;
  assign bias_o       = bias;
  assign osc_en_o     = sys[1];
  assign disp_en_o    = sys[1] & sys[0];
  assign frame_fast_o = frame;
  assign blink_o      = blink;
  assign vadj_o       = vadj;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WACK && scl_fall && inc_pend && !start_det && !stop_det && ptr < lim)
      |=> ptr == $past(ptr) + AW'(1)); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WACK && scl_fall && inc_pend && !start_det && !stop_det && ptr >= lim)
      |=> ptr == '0); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    duty != 2'b11 && bias != 2'b11); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe_o); // R11
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o); // R11
  AST_NO_WRITE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !ram_we); // R10
endmodule

// File: tb/lcd_i2c_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module lcd_i2c_cmd_slave_tb_top;
  localparam int H = 8;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'b0111101;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] scan_addr = '0;
  wire  oe;
  wire  sda_bus = m_sda & ~oe;
  wire [7:0] scan_data;
  wire [1:0] duty, bias, blink;
  wire osc, disp, frame;
  wire [5:0] vadj;

  lcd_i2c_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(oe),
    .scan_addr_i(scan_addr), .scan_data_o(scan_data),
    .duty_o(duty), .bias_o(bias), .osc_en_o(osc), .disp_en_o(disp),
    .frame_fast_o(frame), .blink_o(blink), .vadj_o(vadj));

  int checks = 0, fails = 0;
  logic [7:0] mem_exp [120];
  logic [1:0] e_duty = 0, e_bias = 0, e_sys = 0, e_blink = 0;
  logic e_frame = 0;
  logic [5:0] e_vadj = 6'h30;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [14:0] cfg_now();
    return {duty, bias, osc, disp, frame, blink, vadj};
  endfunction
  function automatic logic [14:0] cfg_exp();
    return {e_duty, e_bias, e_sys[1], e_sys[1] & e_sys[0], e_frame, e_blink, e_vadj};
  endfunction
  function automatic int lim_exp();
    return (e_duty == 0) ? 35 : (e_duty == 1) ? 67 : 119;
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start();
    m_sda = 1; tick(H); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(H);
  endtask
  task automatic bus_stop();
    m_sda = 0; tick(H); m_scl = 1; tick(H); m_sda = 1; tick(2*H);
  endtask
  task automatic send_bit(logic b);
    m_sda = b; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(Q);
  endtask
  task automatic put_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; tick(H); m_scl = 1; tick(Q); ack = !sda_bus; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic get_byte(logic mack, output logic [7:0] d);
    d = '0;
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      tick(H); m_scl = 1; tick(Q); d = {d[6:0], sda_bus}; tick(Q); m_scl = 0; tick(Q);
    end
    m_sda = !mack; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(Q); m_sda = 1;
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] arg);
    logic ack;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R1 address ack", ack, 1);
    put_byte(op, ack);
    put_byte(arg, ack);
    bus_stop();
    chk("R11 released after stop", oe, 0);
  endtask

  task automatic write_data(int a, int n, int seed);
    logic ack; int p; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R1 address ack", ack, 1);
    put_byte(8'h80, ack);
    put_byte(a[7:0], ack);
    p = a;
    for (int i = 0; i < n; i++) begin
      d = 8'((seed + i * 29) ^ (i >> 2));
      put_byte(d, ack); chk("R3 data ack", ack, 1);
      if (p < 120) mem_exp[p] = d;
      p = (p >= lim_exp()) ? 0 : p + 1;
    end
    bus_stop();
  endtask

  task automatic read_data(int a, int n);
    logic ack; int p; logic [7:0] d, e;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h80, ack);
    put_byte(a[7:0], ack);
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R9 read address ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, d);
      e = (p < 120) ? mem_exp[p] : 8'h00;
      chk($sformatf("R9 read byte at %0d", p), d, e);
      p = (p >= lim_exp()) ? 0 : p + 1;
    end
    tick(H);
    chk("R9 released after NACK", oe, 0);
    bus_stop();
  endtask

  task automatic scan_all(string req);
    for (int i = 0; i < 120; i++) begin
      scan_addr = 7'(i); tick(1);
      chk($sformatf("%s scan %0d", req, i), scan_data, mem_exp[i]);
    end
  endtask

  task automatic set_duty(logic [1:0] d);
    cmd(8'h82, {4'b0, d[1], 1'b0, d[0], 1'b0});
    e_duty = d; e_bias = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack; logic [7:0] d;
    for (int i = 0; i < 120; i++) mem_exp[i] = '0;
    tick(5); rst_n = 1; tick(5);
    chk("R2 reset configuration", cfg_now(), cfg_exp());
    chk("R2 reset SDA released", oe, 0);

    // R3 and R4: full memory fill in 1/16 duty, then stream read past the top
    set_duty(2'd2);
    write_data(0, 120, 7);
    scan_all("R3 full fill");
    read_data(0, 121);

    // R4: wrap point per duty code
    for (int dc = 0; dc < 3; dc++) begin
      set_duty(2'(dc));
      write_data(lim_exp() - 1, 3, 50 + dc * 11);
      scan_all($sformatf("R4 wrap duty %0d", dc));
      read_data(lim_exp() - 1, 4);
    end

    // R5: sweep every drive-mode settings nibble
    for (int v = 0; v < 16; v++) begin
      cmd(8'h82, 8'(v));
      if ({v[3], v[1]} != 2'b11 && {v[2], v[0]} != 2'b11) begin
        e_duty = {v[3], v[1]}; e_bias = {v[2], v[0]};
      end
      chk($sformatf("R5 drive setting %0h", v), cfg_now(), cfg_exp());
    end

    // R6: system mode, frame, blink
    for (int v = 0; v < 4; v++) begin
      cmd(8'h84, 8'hF0 | 8'(v)); e_sys = 2'(v);
      chk($sformatf("R6 system %0d", v), cfg_now(), cfg_exp());
    end
    for (int v = 0; v < 2; v++) begin
      cmd(8'h86, 8'hFE | 8'(v)); e_frame = v[0];
      chk($sformatf("R6 frame %0d", v), cfg_now(), cfg_exp());
    end
    for (int v = 0; v < 4; v++) begin
      cmd(8'h88, 8'hFC | 8'(v)); e_blink = 2'(v);
      chk($sformatf("R6 blink %0d", v), cfg_now(), cfg_exp());
    end

    // R7: voltage adjust register
    foreach (mem_exp[i]) if (i < 4) begin
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'h15 : (i == 2) ? 8'hFF : 8'hEA;
      cmd(8'h8A, d); e_vadj = d[5:0];
      chk($sformatf("R7 adjust %0h", d), cfg_now(), cfg_exp());
    end

    // R8: undefined opcodes and trailing bytes
    for (int k = 0; k < 5; k++) begin
      d = (k == 0) ? 8'h81 : (k == 1) ? 8'h83 : (k == 2) ? 8'h8C : (k == 3) ? 8'h00 : 8'hFF;
      cmd(d, 8'hFF);
      chk($sformatf("R8 undefined opcode %0h", d), cfg_now(), cfg_exp());
    end
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h86, ack); put_byte({7'b0, ~e_frame}, ack); e_frame = ~e_frame;
    put_byte(8'h86, ack); put_byte({7'b0, ~e_frame}, ack);
    chk("R8 trailing byte acked", ack, 1);
    put_byte(8'h80, ack); put_byte(8'h10, ack); put_byte(~mem_exp[16], ack);
    bus_stop();
    chk("R8 trailing pair ignored", cfg_now(), cfg_exp());
    scan_addr = 7'd16; tick(1);
    chk("R8 trailing data ignored", scan_data, mem_exp[16]);

    // R1: foreign address
    bus_start();
    put_byte({7'h3C, 1'b0}, ack); chk("R1 foreign address no ack", ack, 0);
    put_byte(8'h86, ack); chk("R1 no ack after mismatch", ack, 0);
    put_byte({7'b0, ~e_frame}, ack);
    bus_stop();
    chk("R1 foreign transfer ignored", cfg_now(), cfg_exp());
    bus_start();
    put_byte({7'h3E, 1'b1}, ack); chk("R1 foreign read no ack", ack, 0);
    get_byte(1'b0, d); chk("R11 bus stays high", d, 8'hFF);
    bus_stop();

    // R10: aborted bytes
    bus_start();
    put_byte({DEV, 1'b0}, ack); put_byte(8'h80, ack); put_byte(8'h10, ack);
    for (int i = 0; i < 4; i++) send_bit(~mem_exp[16][7 - i]);
    bus_stop();
    scan_addr = 7'd16; tick(1);
    chk("R10 stop mid-byte", scan_data, mem_exp[16]);
    bus_start();
    put_byte({DEV, 1'b0}, ack); put_byte(8'h80, ack); put_byte(8'h11, ack);
    for (int i = 0; i < 5; i++) send_bit(~mem_exp[17][7 - i]);
    bus_start();
    put_byte({DEV, 1'b0}, ack); put_byte(8'h86, ack); put_byte({7'b0, ~e_frame}, ack);
    e_frame = ~e_frame;
    bus_stop();
    scan_addr = 7'd17; tick(1);
    chk("R10 start mid-byte", scan_data, mem_exp[17]);
    chk("R10 new transfer after abort", cfg_now(), cfg_exp());

    // R12: beyond memory top
    set_duty(2'd2);
    write_data(8'h7A, 2, 91);
    scan_all("R12 beyond top");
    scan_addr = 7'h7C; tick(1);
    chk("R12 scan beyond top", scan_data, 0);
    read_data(8'h7B, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule